// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block takes an active-low interrupt line from outside the chip and turns it into a request for the interrupt arbiter. The line is first passed through a multi-flop synchroniser. It is then watched either for a falling edge, which is latched until an acknowledge, or for a low level, which is passed straight through. An 8-bit control register sets the detection style, a local enable, and whether requests are held off for a fixed time after reset.

Software writes the control register once during start-up. The arbiter samples `irq_req` and pulses `ack` when it takes an edge-mode request. The register interface and the request/acknowledge pair are plain control pins with no handshake. A write takes effect on the next clock edge, and the register can be read back at any time without side effects.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x20 (hold-off on, level style, disabled) and `irq_req` is 0.
- R2: A write stores bits 7, 6 and 5 of `wr_data`. Bits 4..0 always read as 0, whatever was written.
- R3: With bit 6 = 1, bit 7 = 0 and no hold-off, `irq_req` equals the inverse of `pin_n` as it was two clock edges earlier.
- R4: With bits 7 and 6 = 1, a falling edge on `pin_n` raises `irq_req` on the third clock edge after the pin goes low. The request stays high after the pin returns high, until it is acknowledged.
- R5: In edge style, a one-cycle `ack` pulse with no new falling edge drops `irq_req` at the next clock edge, even while the pin is still low.
- R6: While bit 6 is 0, `irq_req` is 0. A falling edge that occurs while the block is disabled is not remembered when it is enabled later.
- R7: While bit 5 = 1, for HOLDOFF_CYCLES clock edges after reset, `irq_req` stays 0 in either style and falling edges are discarded. After that, a low level is reported and new falling edges are latched.
- R8: With bit 5 = 0, requests are not held off after reset.
- R9: In edge style, a rising edge on `pin_n` never sets a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Asynchronous active-low interrupt line |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: bit 7 edge style, bit 6 enable, bit 5 hold-off |
| rd_data | output | 8 | Control register read-back |
| ack | input | 1 | Acknowledge pulse from the arbiter |
| irq_req | output | 1 | Request to the arbiter |

## Verification
A register write is visible on `rd_data` and in the gating of `irq_req` one edge after the strobe. A level change on the pin reaches `irq_req` after two edges. A falling edge becomes a latched request after three edges, and an acknowledge clears it after one edge. The bench drives every input just after a falling clock edge and samples on the falling edge that follows the due rising edge. For the level sweep it keeps a two-deep history of the driven pin values and compares each sample with the value driven two steps earlier. The hold-off window is checked by triggering a pin edge well inside the window and looking for its absence well after the window has closed.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  typedef struct packed {
    logic edge_sel;
    logic enable;
    logic holdoff;
  } irq_ctrl_t;

  localparam int CTRL_MSB = 7;
  localparam logic [7:0] CTRL_WR_MASK = 8'hE0;
  localparam logic [7:0] CTRL_RESET   = 8'h20;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic running
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= CNT_INIT;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign running = (cnt_q != '0);
endmodule

// File: rtl/irq_detect.sv
module irq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic edge_sel,
  input  logic enable,
  input  logic hold,
  input  logic ack,
  output logic fall_o,
  output logic irq_o
);
  logic prev_q;
  logic pend_q;

  assign fall_o = prev_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (!enable || !edge_sel) pend_q <= 1'b0;
    else if (fall_o && !hold)      pend_q <= 1'b1;
    else if (ack)                  pend_q <= 1'b0;
  end

  assign irq_o = enable & ~hold & (edge_sel ? pend_q : ~pin_s);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pin_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int HOLDOFF_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ack,
  output logic       irq_req
);
  logic [7:0] ctrl_q;
  irq_ctrl_t  ctrl;
  logic       pin_s;
  logic       hold_run;
  logic       holdoff_active;
  logic       fall_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= CTRL_RESET;
    else if (wr_en) ctrl_q <= wr_data & CTRL_WR_MASK;
  end

  assign ctrl    = ctrl_q[CTRL_MSB -: 3];
  assign rd_data = ctrl_q;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_n),
    .q_out (pin_s)
  );

  irq_holdoff #(.CYCLES(HOLDOFF_CYCLES)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (hold_run)
  );

  assign holdoff_active = ctrl.holdoff & hold_run;

  irq_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .edge_sel (ctrl.edge_sel),
    .enable   (ctrl.enable),
    .hold     (holdoff_active),
    .ack      (ack),
    .fall_o   (fall_det),
    .irq_o    (irq_req)
  );
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       wr_en,
  input logic       ack,
  input logic       irq_req,
  input logic       fall_det,
  input logic       holdoff_active
);
  assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:0] == 5'd0);

  assert_no_req_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[6] |-> !irq_req);

  assert_holdoff_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    holdoff_active |-> !irq_req);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rd_data[7] && !fall_det && !wr_en) |=> !irq_req);

  assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:6] == 2'b11 && $past(irq_req) && !$past(ack) && !$past(wr_en))
      |-> irq_req);
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rd_data        (rd_data),
  .wr_en          (wr_en),
  .ack            (ack),
  .irq_req        (irq_req),
  .fall_det       (fall_det),
  .holdoff_active (holdoff_active)
);

// File: tb/irq_pin_ctrl_tb.sv
module irq_pin_ctrl_tb;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ack = 1'b0;
  logic [7:0] rd_data;
  logic       irq_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_pin_ctrl #(.SYNC_STAGES(2), .HOLDOFF_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ack(ack), .irq_req(irq_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_n = 1'b1; wr_en = 1'b0; ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic write_reg(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    tick(1);
    // R1 reset state
    chk("R1 rd", rd_data, 8'h20);
    chk("R1 irq", {7'd0, irq_req}, 8'h00);

    // R2 sweep of every write value
    for (int v = 0; v < 256; v++) begin
      write_reg(8'(v));
      chk("R2", rd_data, 8'(v) & 8'hE0);
    end

    // R3 level-style sweep with pseudo-random pin pattern
    do_reset();
    write_reg(8'h40);
    begin
      logic p1, p2;
      logic [7:0] lf;
      p1 = 1'b1; p2 = 1'b1; lf = 8'hA5;
      for (int k = 0; k < 200; k++) begin
        chk("R3", {7'd0, irq_req}, {7'd0, ~p2});
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        p2 = p1; p1 = lf[0];
        pin_n = p1;
        tick(1);
      end
    end

    // R6 disable masks a low level
    pin_n = 1'b0;
    tick(3);
    chk("R3 low", {7'd0, irq_req}, 8'h01);
    write_reg(8'h00);
    chk("R6 level", {7'd0, irq_req}, 8'h00);

    // R6 edge while disabled is forgotten
    pin_n = 1'b1;
    write_reg(8'h80);
    tick(3);
    pin_n = 1'b0;
    tick(4);
    write_reg(8'hC0);
    tick(1);
    chk("R6 edge", {7'd0, irq_req}, 8'h00);

    // R4 / R8 edge style without hold-off right after reset
    do_reset();
    write_reg(8'hC0);
    tick(2);
    pin_n = 1'b0;
    tick(2);
    chk("R4 early", {7'd0, irq_req}, 8'h00);
    tick(1);
    chk("R4 R8 set", {7'd0, irq_req}, 8'h01);
    pin_n = 1'b1;
    tick(4);
    chk("R4 sticky", {7'd0, irq_req}, 8'h01);
    pulse_ack();
    chk("R5 ack", {7'd0, irq_req}, 8'h00);
    pin_n = 1'b0;
    tick(5);
    chk("R4 second", {7'd0, irq_req}, 8'h01);
    pulse_ack();
    chk("R5 ack low pin", {7'd0, irq_req}, 8'h00);
    tick(2);
    chk("R4 no level", {7'd0, irq_req}, 8'h00);
    pin_n = 1'b1;
    tick(5);
    chk("R9 rising", {7'd0, irq_req}, 8'h00);

    // R8 level style without hold-off
    do_reset();
    wr_en = 1'b1; wr_data = 8'h40; pin_n = 1'b0;
    tick(1);
    wr_en = 1'b0;
    tick(1);
    chk("R8 level", {7'd0, irq_req}, 8'h01);

    // R7 edge discarded during hold-off
    do_reset();
    wr_en = 1'b1; wr_data = 8'hE0; pin_n = 1'b0;
    tick(1);
    wr_en = 1'b0;
    tick(2);
    chk("R7 in window", {7'd0, irq_req}, 8'h00);
    tick(2 * HOLD);
    chk("R7 discarded", {7'd0, irq_req}, 8'h00);
    pin_n = 1'b1;
    tick(3);
    pin_n = 1'b0;
    tick(3);
    chk("R7 after", {7'd0, irq_req}, 8'h01);

    // R7 level held off, then reported
    do_reset();
    wr_en = 1'b1; wr_data = 8'h60; pin_n = 1'b0;
    tick(1);
    wr_en = 1'b0;
    tick(4);
    chk("R7 level held", {7'd0, irq_req}, 8'h00);
    tick(HOLD + 4);
    chk("R7 level after", {7'd0, irq_req}, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule